// File: doc/BRIEF.md
# Four-Channel Compare-Match PWM Timer

This peripheral holds four independent 16-bit timer channels behind a small 16-bit register bus. Each channel has a free-running counter fed through a power-of-four prescaler. It has four compare registers, one of which may be chosen to clear the counter. One output pin per channel is driven by a match-action code. Software sets the channel's pin behaviour, clear source, prescaler and mode while the channel is halted. It then sets the channel's bit in the shared start register. The counter then steps once per prescaled tick.

In PWM mode, the clearing compare sets the period and compare A sets the duty edge. The pin starts each period at its initial level, takes the action coded for compare A when A matches, and goes back to the initial level when the clearing compare matches. Fixed 0 % and 100 % outputs are made by writing a constant-level code to the pin control while the channel is halted. A pin control write moves the pin to its new initial level on the next clock, so the output can be parked without a glitch.

Each channel runs a two-state sequencer. In state HALTED the prescaler and counter are frozen. In state COUNTING the prescaler runs and each tick advances the counter. Transition START (HALTED to COUNTING) is taken on the clock after the channel's start bit reads 1. Transition STOP (COUNTING to HALTED) is taken on the clock after the bit reads 0.

Top module: `cmp_pwm_timer`

## Requirements
- R1: After reset every register reads 0 and every pin is 0.
- R2: Address map. The start register is at byte address 0x00. Channel n's window starts at 0x10 + 0x40*n. Within a window, word offsets 0x00 through 0x24 (step 4) select control, mode, pin control, interrupt enable, status, counter, and compares A, B, C, D. Every such register reads back the last value written, except that the counter reads its live value.
- R3: Bit n of the start register runs channel n. With the bit clear, that channel's counter holds its value. The other channels keep counting.
- R4: While running, the counter advances by one every 4^p input clocks. Here p is control bits [1:0], and bit 2 is ignored, so codes 4 to 7 behave like 0 to 3.
- R5: Control bits [7:5] pick the clearing compare: 1 = A, 2 = B, 5 = C, 6 = D, and any other value = none. On the tick where the counter equals the chosen compare, the counter goes to 0, so the period is (M+1)*4^p clocks.
- R6: PWM mode is selected when mode bits [1:0] = 2. In this mode the pin keeps its initial level for (A+1) ticks of each period and takes the compare-A action until the clearing match. In the test case (pin code 5, clear on B), the output is high for (A+1)*4^p clocks in each (B+1)*4^p clock period.
- R7: Pin control bit 2 is the initial level. Bits [1:0] set the compare-A action: 0 = none, 1 = drive 0, 2 = drive 1, 3 = invert. In normal mode (mode bits [1:0] = 0), the action is applied on each A match and never undone.
- R8: A write to pin control sets the pin to the written bit 2 on the following clock, whether the channel runs or not.
- R9: Mode bits 4 to 6 and control bits [4:3] are stored and read back, but they do not change the waveform.
- R10: When compare A and the clearing compare match on the same tick in PWM mode, the return to the initial level wins, so the pin never leaves its initial level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 9 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| pwm_out | output | 4 | One output pin per channel |

## Verification
The hardest situations to reach are whole-period waveforms measured independently of the prescaler phase, and the coincident match of compare A with the clearing compare. Each waveform case halts the channel, parks the pin and zeroes the counter. It then starts the channel and discards the first rising edge, so that each queued high-time and period is compared against a full cycle. The coincident-match case sets A equal to B and watches the pin for many periods for any departure from its initial level.

// File: rtl/cpt_pkg.sv
package cpt_pkg;

    localparam int NCMP = 4;

    typedef enum logic {
        CH_HALT  = 1'b0,
        CH_COUNT = 1'b1
    } ch_state_e;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_CLR  = 2'd1,
        ACT_SET  = 2'd2,
        ACT_FLIP = 2'd3
    } pin_act_e;

    typedef enum logic [3:0] {
        RS_CTRL = 4'd0,
        RS_MODE = 4'd1,
        RS_PIN  = 4'd2,
        RS_IEN  = 4'd3,
        RS_STAT = 4'd4,
        RS_CNT  = 4'd5,
        RS_CA   = 4'd6,
        RS_CB   = 4'd7,
        RS_CC   = 4'd8,
        RS_CD   = 4'd9,
        RS_NONE = 4'd15
    } reg_sel_e;

    // returns {enable, compare index}
    function automatic logic [2:0] clr_decode(input logic [2:0] code);
        case (code)
            3'd1:    clr_decode = 3'b1_00;
            3'd2:    clr_decode = 3'b1_01;
            3'd5:    clr_decode = 3'b1_10;
            3'd6:    clr_decode = 3'b1_11;
            default: clr_decode = 3'b0_00;
        endcase
    endfunction

endpackage

// File: rtl/cpt_addr_dec.sv
module cpt_addr_dec
    import cpt_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 9
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_start,
    output logic [NCH-1:0]    ch_hit,
    output reg_sel_e          reg_sel
);
    localparam int BASE = 16;
    localparam int SH   = 6;
    localparam int IW   = ADDR_W - SH;

    logic [ADDR_W-1:0] rel;
    logic [IW-1:0]     ch_idx;
    logic              in_win;

    always_comb begin
        rel       = addr - ADDR_W'(BASE);
        ch_idx    = rel[ADDR_W-1:SH];
        in_win    = (addr >= ADDR_W'(BASE)) && (rel[1:0] == 2'b00) && (rel[5:2] <= 4'd9);
        hit_start = (addr == '0);
        reg_sel   = RS_NONE;
        ch_hit    = '0;
        for (int i = 0; i < NCH; i++) begin
            if (in_win && ch_idx == IW'(i)) begin
                ch_hit[i] = 1'b1;
            end
        end
        if (ch_hit != '0) begin
            reg_sel = reg_sel_e'(rel[5:2]);
        end
    end
endmodule

// File: rtl/cpt_prescaler.sv
module cpt_prescaler #(
    parameter int PSW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic [PSW-1:0] code,
    output logic           tick
);
    localparam int DW = 2 * ((1 << PSW) - 1);

    logic [DW-1:0] div_q;
    logic [DW-1:0] lim_m1;

    // divide by 4^code; 4^max wraps to zero, minus one yields all ones
    assign lim_m1 = (DW'(1) << {code, 1'b0}) - DW'(1);
    assign tick   = run && (div_q == lim_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (!run || tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // R4
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && code != '0) |=> !tick);
endmodule

// File: rtl/cpt_channel.sv
module cpt_channel
    import cpt_pkg::*;
#(
    parameter int W   = 16,
    parameter int PSW = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         wr_en,
    input  reg_sel_e     reg_sel,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic         pin
);
    logic [W-1:0] ctrl_q, mode_q, pinc_q, ien_q, stat_q, cnt_q;
    logic [W-1:0] cmp_q [NCMP];

    ch_state_e      state_q, state_d;
    logic           count_en, tick;
    logic [NCMP-1:0] hit;
    logic           clr_en, clr_hit;
    logic [1:0]     clr_idx;
    logic           cnt_wr, pinc_wr, pwm_mode;
    logic           pin_q, pin_d;
    pin_act_e       act;

    assign cnt_wr   = wr_en && (reg_sel == RS_CNT);
    assign pinc_wr  = wr_en && (reg_sel == RS_PIN);
    assign pwm_mode = (mode_q[1:0] == 2'd2);
    assign act      = pin_act_e'(pinc_q[1:0]);

    // sequencer: HALTED <-> COUNTING
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_HALT:  if (run)  state_d = CH_COUNT;
            CH_COUNT: if (!run) state_d = CH_HALT;
        endcase
    end

    assign count_en = (state_q == CH_COUNT);

    cpt_prescaler #(.PSW(PSW)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (count_en),
        .code  (ctrl_q[PSW-1:0]),
        .tick  (tick)
    );

    for (genvar g = 0; g < NCMP; g++) begin : g_hit
        assign hit[g] = tick && (cnt_q == cmp_q[g]);
    end

    always_comb begin
        {clr_en, clr_idx} = clr_decode(ctrl_q[7:5]);
        clr_hit = clr_en && hit[clr_idx];
    end

    // register storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mode_q <= '0;
            pinc_q <= '0;
            ien_q  <= '0;
            stat_q <= '0;
            for (int i = 0; i < NCMP; i++) cmp_q[i] <= '0;
        end else if (wr_en) begin
            case (reg_sel)
                RS_CTRL: ctrl_q   <= wdata;
                RS_MODE: mode_q   <= wdata;
                RS_PIN:  pinc_q   <= wdata;
                RS_IEN:  ien_q    <= wdata;
                RS_STAT: stat_q   <= wdata;
                RS_CA:   cmp_q[0] <= wdata;
                RS_CB:   cmp_q[1] <= wdata;
                RS_CC:   cmp_q[2] <= wdata;
                RS_CD:   cmp_q[3] <= wdata;
                default: ;
            endcase
        end
    end

    // counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_wr) begin
            cnt_q <= wdata;
        end else if (tick) begin
            cnt_q <= clr_hit ? '0 : cnt_q + 1'b1;
        end
    end

    // pin action
    always_comb begin
        pin_d = pin_q;
        if (pinc_wr) begin
            pin_d = wdata[2];
        end else if (pwm_mode && clr_hit) begin
            pin_d = pinc_q[2];
        end else if (hit[0]) begin
            unique case (act)
                ACT_HOLD: pin_d = pin_q;
                ACT_CLR:  pin_d = 1'b0;
                ACT_SET:  pin_d = 1'b1;
                ACT_FLIP: pin_d = ~pin_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pin_d;
    end

    assign pin = pin_q;

    always_comb begin
        case (reg_sel)
            RS_CTRL: rdata = ctrl_q;
            RS_MODE: rdata = mode_q;
            RS_PIN:  rdata = pinc_q;
            RS_IEN:  rdata = ien_q;
            RS_STAT: rdata = stat_q;
            RS_CNT:  rdata = cnt_q;
            RS_CA:   rdata = cmp_q[0];
            RS_CB:   rdata = cmp_q[1];
            RS_CC:   rdata = cmp_q[2];
            RS_CD:   rdata = cmp_q[3];
            default: rdata = '0;
        endcase
    end

    // R3
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_HALT && !cnt_wr) |=> $stable(cnt_q));

    // R5
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && !cnt_wr) |=> (cnt_q == '0));

    // R8
    park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pinc_wr |=> (pin == $past(wdata[2])));

    // R6
    pwm_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_mode && clr_hit && !pinc_wr) |=> (pin == pinc_q[2]));
endmodule

// File: rtl/cmp_pwm_timer.sv
module cmp_pwm_timer
    import cpt_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int W      = 16,
    parameter int PSW    = 2,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    output logic [NCH-1:0]    pwm_out
);
    logic           hit_start;
    logic [NCH-1:0] ch_hit;
    reg_sel_e       reg_sel;
    logic [NCH-1:0] start_q;
    logic [W-1:0]   ch_rdata [NCH];

    cpt_addr_dec #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
        .addr      (bus_addr),
        .hit_start (hit_start),
        .ch_hit    (ch_hit),
        .reg_sel   (reg_sel)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  start_q <= '0;
        else if (bus_wr && hit_start) start_q <= bus_wdata[NCH-1:0];
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        cpt_channel #(.W(W), .PSW(PSW)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (start_q[g]),
            .wr_en   (bus_wr && ch_hit[g]),
            .reg_sel (reg_sel),
            .wdata   (bus_wdata),
            .rdata   (ch_rdata[g]),
            .pin     (pwm_out[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_start) bus_rdata = W'(start_q);
        for (int i = 0; i < NCH; i++) begin
            if (ch_hit[i]) bus_rdata = ch_rdata[i];
        end
    end

    // R2
    dec_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_start && (ch_hit != '0)));
endmodule

// File: tb/cmp_pwm_timer_tb_top.sv
module cmp_pwm_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [3:0]  pwm_out;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    int    exp_hi[$];
    int    exp_per[$];
    string exp_req[$];
    int    mon_ch = 0;
    int    mon_skip = 0;

    always #2.5 clk = ~clk;

    cmp_pwm_timer dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    function automatic logic [8:0] ra(int ch, int idx);
        return 9'(16 + ch * 64 + idx * 4);
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [8:0] a, logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic peek(logic [8:0] a, output int d);
        bus_addr = a;
        #1 d = int'(bus_rdata);
    endtask

    task automatic cfg(int ch, int ctrl, int mode, int pinc, int a, int b, int c);
        wr(9'h000, 16'h0);
        wr(ra(ch, 2), 16'(pinc));
        wr(ra(ch, 0), 16'(ctrl));
        wr(ra(ch, 1), 16'(mode));
        wr(ra(ch, 6), 16'(a));
        wr(ra(ch, 7), 16'(b));
        wr(ra(ch, 8), 16'(c));
        wr(ra(ch, 5), 16'h0);
    endtask

    // driver: start channel, push expected full periods into the scoreboard
    task automatic run_wave(int ch, int hi, int per, int n, string req);
        mon_ch = ch;
        wr(9'h000, 16'(1 << ch));
        mon_skip = 1;
        for (int i = 0; i < n; i++) begin
            exp_hi.push_back(hi); exp_per.push_back(per); exp_req.push_back(req);
        end
        while (exp_hi.size() > 0) @(negedge clk);
        wr(9'h000, 16'h0);
    endtask

    // monitor: measures high time and period on rising edges
    initial begin
        logic prev = 1'b0;
        int cnt = 0;
        int hi = 0;
        forever begin
            @(posedge clk);
            #1;
            if (pwm_out[mon_ch] && !prev) begin
                if (mon_skip > 0) begin
                    mon_skip--;
                end else if (exp_hi.size() > 0) begin
                    check({exp_req[0], " high"}, hi, exp_hi[0]);
                    check({exp_req[0], " period"}, cnt, exp_per[0]);
                    void'(exp_hi.pop_front()); void'(exp_per.pop_front());
                    void'(exp_req.pop_front());
                end
                cnt = 1;
            end else begin
                if (!pwm_out[mon_ch] && prev) hi = cnt;
                cnt++;
            end
            prev = pwm_out[mon_ch];
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int d, d2, e, lows, zeros, mx;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        peek(9'h000, d);   check("R1 start", d, 0);
        peek(ra(0, 0), d); check("R1 ctrl", d, 0);
        peek(ra(3, 9), d); check("R1 cmpD", d, 0);
        peek(ra(2, 5), d); check("R1 cnt", d, 0);
        check("R1 pins", int'(pwm_out), 0);

        // R2 readback across all channel windows
        for (int ch = 0; ch < 4; ch++)
            for (int k = 0; k < 10; k++)
                wr(ra(ch, k), 16'(ch * 256 + k * 17 + 1));
        @(negedge clk);
        for (int ch = 0; ch < 4; ch++)
            for (int k = 0; k < 10; k++) begin
                peek(ra(ch, k), d);
                check("R2 readback", d, ch * 256 + k * 17 + 1);
            end
        wr(9'h000, 16'h5);
        peek(9'h000, d); check("R2 start readback", d, 5);
        wr(9'h000, 16'h0);

        // R8 parking while halted
        wr(ra(0, 2), 16'h4); check("R8 park high", int'(pwm_out[0]), 1);
        wr(ra(0, 2), 16'h0); check("R8 park low", int'(pwm_out[0]), 0);

        // R6 PWM, clear on B, start high, drive 0 at A
        cfg(0, 2 << 5, 2, 5, 9, 29, 0);
        run_wave(0, 10, 30, 3, "R6");
        // R4 prescaler codes
        cfg(0, (2 << 5) | 1, 2, 5, 3, 7, 0);
        run_wave(0, 16, 32, 2, "R4 p1");
        cfg(0, (2 << 5) | 2, 2, 5, 1, 3, 0);
        run_wave(0, 32, 64, 2, "R4 p2");
        cfg(0, (2 << 5) | 5, 2, 5, 3, 7, 0);
        run_wave(0, 16, 32, 2, "R4 alias");
        // R5 clear on compare C, on channel 1
        cfg(1, 5 << 5, 2, 5, 4, 2, 19);
        run_wave(1, 5, 20, 2, "R5 clrC");
        // R9 buffer flags and edge field stored without effect
        cfg(0, (2 << 5) | (2 << 3), 16'h72, 5, 9, 29, 0);
        peek(ra(0, 1), d); check("R9 mode readback", d, 16'h72);
        peek(ra(0, 0), d); check("R9 ctrl readback", d, 16'h50);
        run_wave(0, 10, 30, 2, "R9");
        // R7 normal mode toggle
        cfg(3, 1 << 5, 0, 3, 6, 0, 0);
        run_wave(3, 7, 14, 2, "R7 toggle");
        // R7 normal mode set on match
        cfg(2, 1 << 5, 0, 2, 4, 0, 0);
        check("R7 set initial", int'(pwm_out[2]), 0);
        wr(9'h000, 16'h4);
        repeat (20) @(negedge clk);
        check("R7 set after match", int'(pwm_out[2]), 1);
        repeat (20) @(negedge clk);
        check("R7 set stays", int'(pwm_out[2]), 1);
        wr(9'h000, 16'h0);

        // R10 coincident A and clearing compare
        cfg(0, 2 << 5, 2, 5, 9, 9, 0);
        wr(9'h000, 16'h1);
        lows = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (!pwm_out[0]) lows++;
        end
        check("R10 no departure", lows, 0);
        wr(9'h000, 16'h0);

        // R3 / R4 live count, independent halting
        cfg(0, 0, 0, 0, 100, 100, 100);
        cfg(1, 0, 0, 0, 100, 100, 100);
        wr(9'h000, 16'h3);
        @(negedge clk);
        peek(ra(0, 5), d);
        repeat (10) @(negedge clk);
        peek(ra(0, 5), d2);
        check("R4 live step", d2 - d, 10);
        wr(9'h000, 16'h2);
        repeat (2) @(negedge clk);
        peek(ra(0, 5), d); peek(ra(1, 5), e);
        repeat (10) @(negedge clk);
        peek(ra(0, 5), d2);
        check("R3 halted holds", d2, d);
        peek(ra(1, 5), d2);
        check("R3 other runs", d2 - e, 10);
        wr(9'h000, 16'h0);

        // R5 counter wraps after compare B
        cfg(2, 2 << 5, 0, 0, 100, 5, 0);
        wr(9'h000, 16'h4);
        zeros = 0; mx = 0;
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            peek(ra(2, 5), d);
            if (d == 0) zeros++;
            if (d > mx) mx = d;
        end
        check("R5 max count", mx, 5);
        check("R5 zeros", zeros, 4);
        wr(9'h000, 16'h0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule